// File: doc/BRIEF.md
# Timer/Counter with Capture Channels and Match Outputs

This block is a free-running count engine that sits behind a small word-wide register port. A prescale counter divides an input event stream, and each time the prescale counter hits its terminal value the main count advances by one. The event stream is either every system clock cycle (timer mode) or the selected edges of an external count input, which first passes through a synchronizer (counter mode).

Four compare registers watch the count. When the count reaches the value in a compare register, a match event occurs. Each compare register has its own options. It can raise an interrupt flag, send the count back to zero on the next tick, or halt the engine. It also drives its own output pin with a chosen action, and it emits a one-cycle DMA request pulse. Two capture channels watch external inputs and copy the count into a capture register on a chosen edge. A capture can also raise a flag. All flags are ORed onto one interrupt line, and software clears each flag by writing one to it.

Run control is a three-state machine. `ST_OFF` holds the count frozen. `ST_RUN` lets ticks advance the count. `ST_HOLD` keeps the count and the prescale counter at zero. The transitions are as follows:
- `go` (a control write with bit0=1 and bit4=0) enters `ST_RUN`.
- `halt` (a control write with bit0=0 and bit4=0) enters `ST_OFF`.
- `clear` (a control write with bit4=1) enters `ST_HOLD`.
- `stop_hit` (a match event with stop enabled) moves `ST_RUN` to `ST_OFF`.

A control write always takes priority over `stop_hit`.

Top module: `tmr_capmatch`

## Requirements
- R1: The count advances once every PR+1 prescale inputs, where PR is written at address 2. The prescale counter reads at address 3 and wraps to zero on the input where the count advances.
- R2: CTRL (address 0) bit1=0 selects timer mode, which counts one input per clock. Bit1=1 selects counter mode, which counts edges of `ext_cnt_in` as selected by bits[3:2]: 01 rising, 10 falling, 11 both. The external input is synchronized by two flops before edge detection.
- R3: Control FSM, with CTRL bit0 reading 1 only in `ST_RUN` and bit4 reading 1 only in `ST_HOLD`. In `ST_OFF` the count is frozen. In `ST_HOLD` the count and the prescale counter are zero. A CTRL write takes effect on the next clock edge.
- R4: A match event for compare register i (address 8+i) occurs on the edge where the count becomes equal to it. If MCTRL (address 4) bit 3i+1 is set, the next tick loads zero into the count instead of incrementing it.
- R5: If MCTRL bit 3i+2 is set, a match event moves the FSM to `ST_OFF`. The count stays at the match value and CTRL bit0 reads 0.
- R6: With neither the reset bit nor the stop bit of a compare register set, the count runs through its match value without interruption.
- R7: PINCTRL (address 5) bits[2i+1:2i] select the action of pin i on a match event: 00 none, 01 drive low, 10 drive high, 11 toggle. Writing address 14 loads the pin states directly, and reading it returns them.
- R8: `dma_req[i]` is high for exactly the one cycle after the edge on which match event i occurs.
- R9: CAPCTRL (address 6) bits[3j+2:3j] = {irq, fall, rise} for capture channel j. An enabled edge on `cap_in[j]` copies the count into address 12+j on the third clock edge after the input changes. An edge that is not enabled leaves that register unchanged.
- R10: FLAGS (address 7) holds match flags in bits[3:0] and capture flags in bits[5:4]. A match flag is set only when MCTRL bit 3i is set, and a capture flag only when its irq bit is set. Writing one to a flag clears it. `irq` is high while any flag is set.
- R11: The configuration registers read back what was written, and bits above each field's width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ext_cnt_in | input | 1 | External count input (counter mode) |
| cap_in | input | 2 | Capture trigger inputs |
| match_pin | output | 4 | Per-compare output pins |
| dma_req | output | 4 | Per-compare DMA request pulses |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: 32-bit words, four compare registers and two capture channels. This puts every compare index and every flag bit within reach. With small match and prescale values, wrap-to-zero, halt and pin actions all occur within a few dozen cycles. Two compare registers are arranged to fire on consecutive edges, so DMA pulses on separate lanes can be seen side by side. Short external pulses cover counter mode and capture under each edge selection, including edges that are not enabled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] A_CTRL    = 4'd0;
    localparam logic [REG_AW-1:0] A_COUNT   = 4'd1;
    localparam logic [REG_AW-1:0] A_PR      = 4'd2;
    localparam logic [REG_AW-1:0] A_PC      = 4'd3;
    localparam logic [REG_AW-1:0] A_MCTRL   = 4'd4;
    localparam logic [REG_AW-1:0] A_PINCTRL = 4'd5;
    localparam logic [REG_AW-1:0] A_CAPCTRL = 4'd6;
    localparam logic [REG_AW-1:0] A_FLAGS   = 4'd7;
    localparam logic [REG_AW-1:0] A_MATCH0  = 4'd8;
    localparam logic [REG_AW-1:0] A_CAP0    = 4'd12;
    localparam logic [REG_AW-1:0] A_PINS    = 4'd14;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        PA_NONE   = 2'b00,
        PA_LOW    = 2'b01,
        PA_HIGH   = 2'b10,
        PA_TOGGLE = 2'b11
    } pin_act_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            prev <= sh[STAGES-1];
        end
    end

    assign rise = sh[STAGES-1] & ~prev;
    assign fall = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic          pulse,
    input  logic [DW-1:0] term,
    output logic [DW-1:0] pc,
    output logic          tick
);
    logic at_term;

    assign at_term = (pc >= term);
    assign tick    = run & pulse & at_term;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (hold) begin
            pc <= '0;
        end else if (run && pulse) begin
            pc <= at_term ? '0 : pc + DW'(1);
        end
    end
endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] count_nxt,
    input  logic [DW-1:0] mval,
    input  logic [2:0]    cfg,      // {stop, reset, irq}
    input  logic [1:0]    act,
    input  logic          pin_wr,
    input  logic          pin_wval,
    output logic          hit,
    output logic          irq_evt,
    output logic          rst_req,
    output logic          stop_req,
    output logic          pin,
    output logic          dma
);
    pin_act_t act_e;

    assign act_e    = pin_act_t'(act);
    assign hit      = tick & (count_nxt == mval);
    assign irq_evt  = hit & cfg[0];
    assign rst_req  = tick & (count == mval) & cfg[1];
    assign stop_req = hit & cfg[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (pin_wr) begin
            pin <= pin_wval;
        end else if (hit) begin
            unique case (act_e)
                PA_NONE:   pin <= pin;
                PA_LOW:    pin <= 1'b0;
                PA_HIGH:   pin <= 1'b1;
                PA_TOGGLE: pin <= ~pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dma <= 1'b0;
        else        dma <= hit;
    end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic [2:0]    cfg,      // {irq, fall, rise}
    input  logic [DW-1:0] count,
    output logic [DW-1:0] cap,
    output logic          evt
);
    logic take;

    assign take = (rise & cfg[0]) | (fall & cfg[1]);
    assign evt  = take & cfg[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap <= '0;
        else if (take) cap <= count;
    end
endmodule

// File: rtl/tmr_capmatch.sv
module tmr_capmatch
    import tmr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int N_MATCH     = 4,
    parameter int N_CAP       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic               ext_cnt_in,
    input  logic [N_CAP-1:0]   cap_in,
    output logic [N_MATCH-1:0] match_pin,
    output logic [N_MATCH-1:0] dma_req,
    output logic               irq
);
    localparam int MC_W = 3 * N_MATCH;
    localparam int PA_W = 2 * N_MATCH;
    localparam int CC_W = 3 * N_CAP;
    localparam int FL_W = N_MATCH + N_CAP;

    // register write decode
    logic wr_ctrl, wr_count, wr_pr, wr_mctrl, wr_pinctrl, wr_capctrl, wr_flags, wr_pins;

    assign wr_ctrl    = wr_en && (addr == A_CTRL);
    assign wr_count   = wr_en && (addr == A_COUNT);
    assign wr_pr      = wr_en && (addr == A_PR);
    assign wr_mctrl   = wr_en && (addr == A_MCTRL);
    assign wr_pinctrl = wr_en && (addr == A_PINCTRL);
    assign wr_capctrl = wr_en && (addr == A_CAPCTRL);
    assign wr_flags   = wr_en && (addr == A_FLAGS);
    assign wr_pins    = wr_en && (addr == A_PINS);

    // configuration storage
    logic            mode_q;
    logic [1:0]      edge_q;
    logic [DW-1:0]   pr_q;
    logic [MC_W-1:0] mctrl_q;
    logic [PA_W-1:0] pinctrl_q;
    logic [CC_W-1:0] capctrl_q;
    logic [DW-1:0]   match_q [N_MATCH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            edge_q    <= 2'b00;
            pr_q      <= '0;
            mctrl_q   <= '0;
            pinctrl_q <= '0;
            capctrl_q <= '0;
            for (int i = 0; i < N_MATCH; i++) match_q[i] <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= wdata[1];
                edge_q <= wdata[3:2];
            end
            if (wr_pr)      pr_q      <= wdata;
            if (wr_mctrl)   mctrl_q   <= wdata[MC_W-1:0];
            if (wr_pinctrl) pinctrl_q <= wdata[PA_W-1:0];
            if (wr_capctrl) capctrl_q <= wdata[CC_W-1:0];
            for (int i = 0; i < N_MATCH; i++) begin
                if (wr_en && (addr == A_MATCH0 + REG_AW'(i))) match_q[i] <= wdata;
            end
        end
    end

    // run-control state machine
    run_state_t state, state_nxt;
    logic       run, hold;
    logic [N_MATCH-1:0] stop_req;

    function automatic run_state_t ctrl_target(input logic [DW-1:0] d);
        if (d[4])      return ST_HOLD;
        else if (d[0]) return ST_RUN;
        else           return ST_OFF;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (wr_ctrl) state_nxt = ctrl_target(wdata);
            end
            ST_RUN: begin
                if (wr_ctrl)          state_nxt = ctrl_target(wdata);
                else if (|stop_req)   state_nxt = ST_OFF;
            end
            ST_HOLD: begin
                if (wr_ctrl) state_nxt = ctrl_target(wdata);
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_comb begin
        run  = 1'b0;
        hold = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_RUN:  run  = 1'b1;
            ST_HOLD: hold = 1'b1;
            default: ;
        endcase
    end

    // prescale input selection
    logic ext_rise, ext_fall, cnt_pulse;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_cnt_in),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    assign cnt_pulse = mode_q ? ((edge_q[0] & ext_rise) | (edge_q[1] & ext_fall)) : 1'b1;

    logic [DW-1:0] pc_q;
    logic          tick;

    tmr_prescaler #(.DW(DW)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .hold (hold),
        .pulse(cnt_pulse),
        .term (pr_q),
        .pc   (pc_q),
        .tick (tick)
    );

    // main count
    logic [DW-1:0]      count_q, count_adv;
    logic [N_MATCH-1:0] hit, m_irq, rst_req;

    assign count_adv = (|rst_req) ? '0 : count_q + DW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count_q <= '0;
        else if (hold)     count_q <= '0;
        else if (wr_count) count_q <= wdata;
        else if (tick)     count_q <= count_adv;
    end

    // compare units
    for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_match
        tmr_match #(.DW(DW)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .count    (count_q),
            .count_nxt(count_adv),
            .mval     (match_q[gi]),
            .cfg      (mctrl_q[3*gi +: 3]),
            .act      (pinctrl_q[2*gi +: 2]),
            .pin_wr   (wr_pins),
            .pin_wval (wdata[gi]),
            .hit      (hit[gi]),
            .irq_evt  (m_irq[gi]),
            .rst_req  (rst_req[gi]),
            .stop_req (stop_req[gi]),
            .pin      (match_pin[gi]),
            .dma      (dma_req[gi])
        );
    end

    // capture channels
    logic [DW-1:0]    cap_q [N_CAP];
    logic [N_CAP-1:0] c_irq;

    for (genvar gj = 0; gj < N_CAP; gj++) begin : g_cap
        logic c_rise, c_fall;

        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (cap_in[gj]),
            .rise (c_rise),
            .fall (c_fall)
        );

        tmr_capture #(.DW(DW)) u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .rise (c_rise),
            .fall (c_fall),
            .cfg  (capctrl_q[3*gj +: 3]),
            .count(count_q),
            .cap  (cap_q[gj]),
            .evt  (c_irq[gj])
        );
    end

    // interrupt flags, write one to clear, new events win
    logic [FL_W-1:0] flags_q, flag_clr;

    assign flag_clr = wr_flags ? wdata[FL_W-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | {c_irq, m_irq};
    end

    assign irq = |flags_q;

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[0]   = (state == ST_RUN);
                rdata[1]   = mode_q;
                rdata[3:2] = edge_q;
                rdata[4]   = (state == ST_HOLD);
            end
            A_COUNT:   rdata = count_q;
            A_PR:      rdata = pr_q;
            A_PC:      rdata = pc_q;
            A_MCTRL:   rdata[MC_W-1:0] = mctrl_q;
            A_PINCTRL: rdata[PA_W-1:0] = pinctrl_q;
            A_CAPCTRL: rdata[CC_W-1:0] = capctrl_q;
            A_FLAGS:   rdata[FL_W-1:0] = flags_q;
            A_PINS:    rdata[N_MATCH-1:0] = match_pin;
            default:   ;
        endcase
        for (int i = 0; i < N_MATCH; i++) begin
            if (addr == A_MATCH0 + REG_AW'(i)) rdata = match_q[i];
        end
        for (int j = 0; j < N_CAP; j++) begin
            if (addr == A_CAP0 + REG_AW'(j)) rdata = cap_q[j];
        end
    end
endmodule

// File: rtl/tmr_capmatch_chk.sv
module tmr_capmatch_chk
    import tmr_pkg::*;
#(
    parameter int DW      = 32,
    parameter int N_MATCH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_AW-1:0]  addr,
    input run_state_t         state,
    input logic [DW-1:0]      count,
    input logic [DW-1:0]      pc,
    input logic [DW-1:0]      pr,
    input logic [N_MATCH-1:0] stop_req,
    input logic [N_MATCH-1:0] hit,
    input logic               wr_pins,
    input logic [N_MATCH-1:0] match_pin
);
    // R1: the prescale counter never passes an unchanged terminal value
    p_pc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pr) && $past(pc <= pr)) |-> (pc <= pr));

    // R3: with no register access the count is frozen while off
    p_off_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !wr_en) |=> $stable(count));

    // R3: the hold state leaves count and prescale counter at zero
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (count == '0 && pc == '0));

    // R5: a stop-enabled match halts the engine unless a control write arrives
    p_stop_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && |stop_req && !(wr_en && addr == A_CTRL)) |=> (state == ST_OFF));

    // R7: pins only move on a match event or a direct pin write
    p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit) && !wr_pins) |=> $stable(match_pin));
endmodule

bind tmr_capmatch tmr_capmatch_chk #(.DW(DW), .N_MATCH(N_MATCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .state    (state),
    .count    (count_q),
    .pc       (pc_q),
    .pr       (pr_q),
    .stop_req (stop_req),
    .hit      (hit),
    .wr_pins  (wr_pins),
    .match_pin(match_pin)
);

// File: tb/tmr_capmatch_tb.sv
module tmr_capmatch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    // {write, addr, data, expected}
    localparam logic [68:0] TBL [NV] = '{
        {1'b1, 4'd8,  32'hDEADBEEF, 32'h0},
        {1'b0, 4'd8,  32'h0,        32'hDEADBEEF},
        {1'b1, 4'd11, 32'h00000100, 32'h0},
        {1'b0, 4'd11, 32'h0,        32'h00000100},
        {1'b1, 4'd2,  32'h7,        32'h0},
        {1'b0, 4'd2,  32'h0,        32'h7},
        {1'b1, 4'd4,  32'hFFFFFFFF, 32'h0},
        {1'b0, 4'd4,  32'h0,        32'h00000FFF},
        {1'b1, 4'd4,  32'h0,        32'h0},
        {1'b0, 4'd4,  32'h0,        32'h0},
        {1'b1, 4'd1,  32'hCAFE0001, 32'h0},
        {1'b0, 4'd1,  32'h0,        32'hCAFE0001},
        {1'b1, 4'd5,  32'hFFFFFFFF, 32'h0},
        {1'b0, 4'd5,  32'h0,        32'h000000FF},
        {1'b1, 4'd5,  32'h0,        32'h0},
        {1'b1, 4'd1,  32'h0,        32'h0},
        {1'b1, 4'd2,  32'h0,        32'h0},
        {1'b0, 4'd12, 32'h0,        32'h0},
        {1'b0, 4'd3,  32'h0,        32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_cnt_in = 1'b0;
    logic [1:0]  cap_in = '0;
    logic [3:0]  match_pin, dma_req;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_capmatch u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .ext_cnt_in(ext_cnt_in),
        .cap_in    (cap_in),
        .match_pin (match_pin),
        .dma_req   (dma_req),
        .irq       (irq)
    );

    // called at a falling edge; write lands on the next rising edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_v(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_r(input string tag, input logic [3:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk_v(tag, rdata, exp);
    endtask

    task automatic pulse_ext();
        ext_cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        ext_cnt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R3, R10)
        chk_r("R3 reset ctrl", 4'd0, 32'h0);
        chk_r("R3 reset count", 4'd1, 32'h0);
        chk_r("R10 reset flags", 4'd7, 32'h0);
        chk_r("R7 reset pins", 4'd14, 32'h0);
        chk_v("R10 reset irq", {31'b0, irq}, 32'h0);
        chk_v("R8 reset dma", {28'b0, dma_req}, 32'h0);

        // register table (R11)
        for (int i = 0; i < NV; i++) begin
            if (TBL[i][68]) wr(TBL[i][67:64], TBL[i][63:32]);
            else            chk_r("R11 table", TBL[i][67:64], TBL[i][31:0]);
        end

        // R1 timer mode, no prescale: ten edges in run
        wr(4'd1, 0);
        wr(4'd0, 32'h1);
        repeat (9) @(negedge clk);
        wr(4'd0, 32'h0);
        chk_r("R1 R2 timer count", 4'd1, 32'd10);

        // R1 prescale 3, eighteen edges in run
        wr(4'd1, 0);
        wr(4'd2, 32'd3);
        wr(4'd0, 32'h1);
        repeat (17) @(negedge clk);
        wr(4'd0, 32'h0);
        chk_r("R1 prescaled count", 4'd1, 32'd4);
        chk_r("R1 prescale counter", 4'd3, 32'd2);
        wr(4'd2, 32'd0);

        // R3 hold, resume, freeze
        wr(4'd1, 0);
        wr(4'd0, 32'h1);
        repeat (4) @(negedge clk);
        wr(4'd0, 32'h11);
        repeat (2) @(negedge clk);
        chk_r("R3 hold count", 4'd1, 32'd0);
        chk_r("R3 hold ctrl", 4'd0, 32'h10);
        wr(4'd0, 32'h1);
        repeat (2) @(negedge clk);
        chk_r("R3 resumed count", 4'd1, 32'd2);
        wr(4'd0, 32'h0);
        repeat (5) @(negedge clk);
        chk_r("R3 off frozen", 4'd1, 32'd3);

        // R4 reset on match with irq, twelve edges
        wr(4'd1, 0);
        wr(4'd8, 32'd4);
        wr(4'd4, 32'h3);
        wr(4'd0, 32'h1);
        repeat (11) @(negedge clk);
        wr(4'd0, 32'h0);
        chk_r("R4 wrapped count", 4'd1, 32'd2);
        chk_r("R10 match0 flag", 4'd7, 32'h1);
        chk_v("R10 irq high", {31'b0, irq}, 32'h1);
        wr(4'd7, 32'h1);
        chk_r("R10 w1c flags", 4'd7, 32'h0);
        chk_v("R10 irq low", {31'b0, irq}, 32'h0);

        // R5 stop on match1 = 6
        wr(4'd4, 32'h0);
        wr(4'd1, 0);
        wr(4'd9, 32'd6);
        wr(4'd4, 32'h20);
        wr(4'd0, 32'h1);
        repeat (20) @(negedge clk);
        chk_r("R5 stopped count", 4'd1, 32'd6);
        chk_r("R5 ctrl run bit", 4'd0, 32'h0);
        chk_r("R10 no flag without irq enable", 4'd7, 32'h0);

        // R6 run through match2 = 3 with irq only
        wr(4'd4, 32'h40);
        wr(4'd10, 32'd3);
        wr(4'd1, 0);
        wr(4'd0, 32'h1);
        repeat (7) @(negedge clk);
        wr(4'd0, 32'h0);
        chk_r("R6 count passes match", 4'd1, 32'd8);
        chk_r("R6 R10 match2 flag", 4'd7, 32'h4);
        wr(4'd7, 32'h3F);

        // R8 dma pulses: match0 = 2, match2 = 3
        wr(4'd4, 32'h0);
        wr(4'd1, 0);
        wr(4'd8, 32'd2);
        wr(4'd0, 32'h1);
        @(negedge clk);
        chk_v("R8 dma before match", {28'b0, dma_req}, 32'h0);
        @(negedge clk);
        chk_v("R8 dma lane0", {28'b0, dma_req}, 32'h1);
        @(negedge clk);
        chk_v("R8 dma lane2 only", {28'b0, dma_req}, 32'h4);
        wr(4'd0, 32'h0);
        chk_v("R8 dma ends", {28'b0, dma_req}, 32'h0);

        // R7 pin actions
        wr(4'd14, 32'h4);
        chk_r("R7 pin direct write", 4'd14, 32'h4);
        wr(4'd8, 32'd2);
        wr(4'd9, 32'd3);
        wr(4'd10, 32'd5);
        wr(4'd11, 32'd1);
        wr(4'd5, 32'h1B);
        wr(4'd1, 0);
        wr(4'd0, 32'h1);
        repeat (7) @(negedge clk);
        wr(4'd0, 32'h0);
        chk_v("R7 pin actions", {28'b0, match_pin}, 32'h3);
        chk_r("R7 pin readback", 4'd14, 32'h3);
        wr(4'd5, 32'h0);

        // R9 capture
        wr(4'd1, 32'h1234);
        wr(4'd6, 32'h15);
        cap_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk_r("R9 capture ch0 rise", 4'd12, 32'h1234);
        chk_r("R9 R10 capture flag", 4'd7, 32'h10);
        wr(4'd1, 32'h55);
        cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk_r("R9 disabled fall ignored", 4'd12, 32'h1234);
        cap_in[1] = 1'b1;
        repeat (4) @(negedge clk);
        chk_r("R9 disabled rise ignored", 4'd13, 32'h0);
        cap_in[1] = 1'b0;
        repeat (3) @(negedge clk);
        chk_r("R9 capture ch1 fall", 4'd13, 32'h55);
        chk_r("R10 ch1 no irq flag", 4'd7, 32'h10);
        wr(4'd7, 32'h10);
        chk_v("R10 irq cleared", {31'b0, irq}, 32'h0);

        // R2 counter mode
        wr(4'd1, 0);
        wr(4'd0, 32'h7);
        for (int k = 0; k < 3; k++) pulse_ext();
        chk_r("R2 rising edges", 4'd1, 32'd3);
        wr(4'd0, 32'hF);
        for (int k = 0; k < 2; k++) pulse_ext();
        chk_r("R2 both edges", 4'd1, 32'd7);
        wr(4'd0, 32'hB);
        pulse_ext();
        chk_r("R2 falling edge", 4'd1, 32'd8);
        chk_r("R2 ctrl readback", 4'd0, 32'hB);
        wr(4'd0, 32'h0);

        summary();
        $finish;
    end
endmodule